// File: doc/BRIEF.md
# Keyboard Controller Register Interface

This block gives host software a two-register window onto a keyboard. Software polls a status byte, reads scancodes out of a one-byte output buffer and writes command bytes. The command set has three operations: run a self test, switch the keyboard on, and load the indicator lamps. Scancodes come in from the device side on a byte-wide strobe. Three lamp outputs go back toward the keyboard.

The host bus is a plain select/write/address/data port. A write lands on the rising clock edge of the cycle in which `bus_sel` is high. Read data is combinational from the current register state, so a read returns its byte in the same cycle. Any side effect of that read, such as clearing a flag, takes hold at the closing clock edge.

Top module: `kbc_regif`

## Requirements
- R1: After reset the status byte is 0x00, the data register reads 0x00 and the lamp output is 0.
- R2: A read at offset 0x64 returns the status byte. Its bits are: bit 0 output-buffer-full, bit 1 controller busy, bit 2 overrun, bit 3 keyboard enabled, bit 4 lamp argument pending. Bits 7 to 5 read zero.
- R3: Until command 0xAE has been written after reset, scancode strobes are ignored. Output-buffer-full and overrun stay clear.
- R4: Once the keyboard is enabled, a scancode that arrives while the buffer is empty and the controller is not busy is stored, and output-buffer-full is set after that cycle. A read at offset 0x60 returns the stored byte and clears output-buffer-full at the end of the read cycle.
- R5: A scancode that arrives while the keyboard is enabled and either output-buffer-full or busy is set is discarded. The stored byte stays unchanged and overrun is set. A status read returns the overrun bit and then clears it, unless a new discard happens in the same cycle.
- R6: Command 0xAA sets busy for exactly one cycle. At the end of that cycle the data register holds 0x55, output-buffer-full is set and busy clears. The command also cancels a pending lamp argument.
- R7: Command 0xED sets lamp-argument-pending. The next write at offset 0x60 drives bits 2:0 of the written byte onto the lamp output and clears the pending bit.
- R8: A write at offset 0x60 with no argument pending leaves the lamp output and all status bits unchanged.
- R9: Command 0xAA or 0xAE written while a lamp argument is pending cancels it, so the next data write does not change the lamps.
- R10: A command byte other than 0xAA, 0xAE or 0xED changes no state.
- R11: Host writes made while busy is set are ignored. Reads at any offset other than 0x60 and 0x64, and cycles with the write strobe high, return 0x00 on the read data port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Host access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte (combinational) |
| kb_valid | input | 1 | Scancode strobe from the device side |
| kb_code | input | 8 | Scancode byte |
| led | output | 3 | Keyboard lamp drive |

## Verification
The hardest case to reach is a collision. A scancode, a data-register read and the self-test completion can all fall on the same edge. A status read can also coincide with a fresh discard. These collisions decide whether the overrun bit and output-buffer-full end up set or clear. Directed sequences place a scancode in the one busy cycle after 0xAA and a second scancode on a full buffer. A long random phase then draws the device strobe independently of the host access every cycle, so that reads, commands and arrivals overlap in all orders. A bench reference model predicts every read byte and the lamp output.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

   localparam logic [7:0] CMD_SELFTEST = 8'hAA;
   localparam logic [7:0] CMD_ENABLE   = 8'hAE;
   localparam logic [7:0] CMD_SETLED   = 8'hED;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_TEST,
      OP_ENABLE,
      OP_LEDARM
   } kbc_op_e;

   // status byte, MSB first
   typedef struct packed {
      logic [2:0] rsvd;
      logic       arg_pend;
      logic       kbd_on;
      logic       ovr;
      logic       busy;
      logic       obf;
   } kbc_status_t;

   function automatic kbc_op_e decode_cmd(input logic [7:0] code);
      kbc_op_e op;
      case (code)
         CMD_SELFTEST: op = OP_TEST;
         CMD_ENABLE:   op = OP_ENABLE;
         CMD_SETLED:   op = OP_LEDARM;
         default:      op = OP_NONE;
      endcase
      return op;
   endfunction

endpackage

// File: rtl/kbc_bus_decode.sv
module kbc_bus_decode #(
   parameter int          ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] DATA_OFS = 8'h60,
   parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h64,
   parameter bit          SPARSE   = 1'b0
) (
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              rd_data_o,
   output logic              rd_ctrl_o,
   output logic              wr_data_o,
   output logic              wr_ctrl_o
);

   localparam logic [ADDR_W-1:0] DIFF_MASK = DATA_OFS ^ CTRL_OFS;

   logic hit_data;
   logic hit_ctrl;

   if (DATA_OFS == CTRL_OFS) begin : g_bad_offsets
      initial $fatal(1, "kbc_bus_decode: register offsets must differ");
   end

   if (SPARSE) begin : g_sparse
      // compare only the bits that tell the two registers apart
      assign hit_data = ((addr_i ^ DATA_OFS) & DIFF_MASK) == '0;
      assign hit_ctrl = ((addr_i ^ CTRL_OFS) & DIFF_MASK) == '0;
   end else begin : g_full
      assign hit_data = (addr_i == DATA_OFS);
      assign hit_ctrl = (addr_i == CTRL_OFS);
   end

   assign rd_data_o = sel_i && !wr_i && hit_data;
   assign rd_ctrl_o = sel_i && !wr_i && hit_ctrl;
   assign wr_data_o = sel_i &&  wr_i && hit_data;
   assign wr_ctrl_o = sel_i &&  wr_i && hit_ctrl;

endmodule

// File: rtl/kbc_cmd_ctrl.sv
module kbc_cmd_ctrl
   import kbc_pkg::*;
#(
   parameter int DW    = 8,
   parameter int LED_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctrl_i,
   input  logic             wr_data_i,
   input  logic [DW-1:0]    wdata_i,
   output logic             busy_o,
   output logic             kbd_on_o,
   output logic             arg_pend_o,
   output logic [LED_W-1:0] led_o
);

   if (LED_W < 1 || LED_W > DW) begin : g_bad_led_w
      initial $fatal(1, "kbc_cmd_ctrl: LED_W must lie in 1..DW");
   end
   if (DW != 8) begin : g_bad_dw
      initial $fatal(1, "kbc_cmd_ctrl: command codes are byte wide");
   end

   logic             busy_q;
   logic             kbd_on_q;
   logic             pend_q;
   logic [LED_W-1:0] led_q;

   logic    host_ok;
   logic    cmd_take;
   logic    arg_take;
   kbc_op_e op;

   assign host_ok  = !busy_q;
   assign cmd_take = wr_ctrl_i && host_ok;
   assign arg_take = wr_data_i && host_ok && pend_q;
   assign op       = decode_cmd(wdata_i[7:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         kbd_on_q <= 1'b0;
         pend_q   <= 1'b0;
         led_q    <= '0;
      end else begin
         busy_q <= cmd_take && (op == OP_TEST);
         if (cmd_take && op == OP_ENABLE) kbd_on_q <= 1'b1;
         if (cmd_take) begin
            case (op)
               OP_TEST, OP_ENABLE: pend_q <= 1'b0;
               OP_LEDARM:          pend_q <= 1'b1;
               default:            pend_q <= pend_q;
            endcase
         end else if (arg_take) begin
            pend_q <= 1'b0;
         end
         if (arg_take) led_q <= wdata_i[LED_W-1:0];
      end
   end

   assign busy_o     = busy_q;
   assign kbd_on_o   = kbd_on_q;
   assign arg_pend_o = pend_q;
   assign led_o      = led_q;

   AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> !busy_q);  // R6
   AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      kbd_on_q |=> kbd_on_q);  // R3
   AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_data_i && pend_q) |=> $stable(led_q));  // R8
   AST_LED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data_i && pend_q && !busy_q) |=> (!pend_q && led_q == $past(wdata_i[LED_W-1:0])));  // R7
   AST_UNKNOWN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl_i && wdata_i != CMD_SELFTEST && wdata_i != CMD_ENABLE && wdata_i != CMD_SETLED)
      |=> ($stable(kbd_on_q) && $stable(pend_q) && $stable(led_q) && !busy_q));  // R10
   AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> ($stable(kbd_on_q) && $stable(led_q)));  // R11

endmodule

// File: rtl/kbc_outbuf.sv
module kbc_outbuf #(
   parameter int          DW      = 8,
   parameter logic [DW-1:0] ST_PASS = 8'h55
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          kb_valid_i,
   input  logic [DW-1:0] kb_code_i,
   input  logic          kbd_on_i,
   input  logic          st_done_i,
   input  logic          rd_data_i,
   input  logic          rd_ctrl_i,
   output logic [DW-1:0] data_o,
   output logic          obf_o,
   output logic          ovr_o
);

   logic [DW-1:0] data_q;
   logic          obf_q;
   logic          ovr_q;

   logic arrive;
   logic accept;
   logic drop;

   assign arrive = kb_valid_i && kbd_on_i;
   assign drop   = arrive && (obf_q || st_done_i);
   assign accept = arrive && !obf_q && !st_done_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         obf_q  <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (st_done_i) begin
            data_q <= ST_PASS;
            obf_q  <= 1'b1;
         end else if (accept) begin
            data_q <= kb_code_i;
            obf_q  <= 1'b1;
         end else if (rd_data_i) begin
            obf_q  <= 1'b0;
         end
         if (drop)           ovr_q <= 1'b1;
         else if (rd_ctrl_i) ovr_q <= 1'b0;
      end
   end

   assign data_o = data_q;
   assign obf_o  = obf_q;
   assign ovr_o  = ovr_q;

   AST_NO_FILL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!kbd_on_i && !st_done_i && !obf_q) |=> !obf_q);  // R3
   AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      (kb_valid_i && kbd_on_i && obf_q) |=> ovr_q);  // R5
   AST_FULL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (obf_q && !st_done_i) |=> $stable(data_q));  // R5
   AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (kb_valid_i && kbd_on_i && !obf_q && !st_done_i) |=> (obf_q && data_q == $past(kb_code_i)));  // R4

endmodule

// File: rtl/kbc_regif.sv
module kbc_regif
   import kbc_pkg::*;
#(
   parameter int        ADDR_W   = 8,
   parameter int        DW       = 8,
   parameter int        LED_W    = 3,
   parameter logic [ADDR_W-1:0] DATA_OFS = 8'h60,
   parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h64,
   parameter logic [DW-1:0]     ST_PASS  = 8'h55,
   parameter bit        SPARSE   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic              kb_valid,
   input  logic [DW-1:0]     kb_code,
   output logic [LED_W-1:0]  led
);

   localparam int STAT_W = $bits(kbc_status_t);

   if (STAT_W != DW) begin : g_bad_status_w
      initial $fatal(1, "kbc_regif: status byte must match data width");
   end

   logic          rd_data, rd_ctrl, wr_data, wr_ctrl;
   logic          busy, kbd_on, arg_pend;
   logic [DW-1:0] data_q;
   logic          obf, ovr;
   kbc_status_t   status;

   kbc_bus_decode #(
      .ADDR_W   (ADDR_W),
      .DATA_OFS (DATA_OFS),
      .CTRL_OFS (CTRL_OFS),
      .SPARSE   (SPARSE)
   ) u_dec (
      .sel_i     (bus_sel),
      .wr_i      (bus_wr),
      .addr_i    (bus_addr),
      .rd_data_o (rd_data),
      .rd_ctrl_o (rd_ctrl),
      .wr_data_o (wr_data),
      .wr_ctrl_o (wr_ctrl)
   );

   kbc_cmd_ctrl #(
      .DW    (DW),
      .LED_W (LED_W)
   ) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ctrl_i  (wr_ctrl),
      .wr_data_i  (wr_data),
      .wdata_i    (bus_wdata),
      .busy_o     (busy),
      .kbd_on_o   (kbd_on),
      .arg_pend_o (arg_pend),
      .led_o      (led)
   );

   kbc_outbuf #(
      .DW      (DW),
      .ST_PASS (ST_PASS)
   ) u_obuf (
      .clk        (clk),
      .rst_n      (rst_n),
      .kb_valid_i (kb_valid),
      .kb_code_i  (kb_code),
      .kbd_on_i   (kbd_on),
      .st_done_i  (busy),
      .rd_data_i  (rd_data),
      .rd_ctrl_i  (rd_ctrl),
      .data_o     (data_q),
      .obf_o      (obf),
      .ovr_o      (ovr)
   );

   always_comb begin
      status          = '0;
      status.arg_pend = arg_pend;
      status.kbd_on   = kbd_on;
      status.ovr      = ovr;
      status.busy     = busy;
      status.obf      = obf;
   end

   always_comb begin
      if (rd_data)      bus_rdata = data_q;
      else if (rd_ctrl) bus_rdata = status;
      else              bus_rdata = '0;
   end

   AST_SELFTEST_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (obf && data_q == ST_PASS && !busy));  // R6
   AST_READ_CLEARS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !busy && !(kb_valid && kbd_on && !obf)) |=> !obf);  // R4
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ctrl |-> (bus_rdata[7:5] == 3'b000));  // R2
   AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_data || rd_ctrl) |-> (bus_rdata == '0));  // R11

endmodule

// File: tb/kbc_regif_test.sv
`timescale 1ns/1ps
module kbc_regif_test;

   localparam logic [7:0] A_DATA = 8'h60;
   localparam logic [7:0] A_CTRL = 8'h64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       kb_valid = 1'b0;
   logic [7:0] kb_code = '0;
   logic [2:0] led;

   int checks = 0;
   int errors = 0;

   // reference model state
   bit       m_obf, m_busy, m_ovr, m_en, m_pend;
   bit [2:0] m_led;
   bit [7:0] m_data;

   always #2.5 clk = ~clk;

   kbc_regif uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .kb_valid  (kb_valid),
      .kb_code   (kb_code),
      .led       (led)
   );

   function automatic bit [7:0] exp_status();
      return {3'b000, m_pend, m_en, m_ovr, m_busy, m_obf};
   endfunction

   function automatic bit [7:0] exp_rdata(bit sel, bit wr, bit [7:0] addr);
      if (!sel || wr)       return 8'h00;
      if (addr == A_DATA)   return m_data;
      if (addr == A_CTRL)   return exp_status();
      return 8'h00;
   endfunction

   task automatic check8(string tag, logic [7:0] got, logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", tag, got, exp, $time);
      end
   endtask

   // model update from the pre-edge state and this cycle's inputs
   task automatic model_step(bit sel, bit wr, bit [7:0] addr, bit [7:0] wd, bit kbv, bit [7:0] kbc);
      bit st_done = m_busy;
      bit acc_w   = sel && wr && !m_busy;
      bit rd_d    = sel && !wr && addr == A_DATA;
      bit rd_c    = sel && !wr && addr == A_CTRL;
      bit arrive  = kbv && m_en;
      bit n_busy  = 1'b0;
      if (st_done) begin
         m_data = 8'h55; m_obf = 1'b1;
      end else if (arrive && !m_obf) begin
         m_data = kbc; m_obf = 1'b1;
      end else if (rd_d) begin
         m_obf = 1'b0;
      end
      if (arrive && (m_obf_pre(st_done))) m_ovr = 1'b1;
      else if (rd_c) m_ovr = 1'b0;
      if (acc_w && addr == A_CTRL) begin
         case (wd)
            8'hAA: begin n_busy = 1'b1; m_pend = 1'b0; end
            8'hAE: begin m_en = 1'b1; m_pend = 1'b0; end
            8'hED: m_pend = 1'b1;
            default: ;
         endcase
      end else if (acc_w && addr == A_DATA && m_pend) begin
         m_led = wd[2:0]; m_pend = 1'b0;
      end
      m_busy = n_busy;
   endtask

   bit pre_obf;
   function automatic bit m_obf_pre(bit st_done);
      return pre_obf || st_done;
   endfunction

   // one bus cycle: inputs driven after a falling edge
   task automatic cyc(bit sel, bit wr, bit [7:0] addr, bit [7:0] wd, bit kbv, bit [7:0] kbc, string tag);
      bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
      kb_valid = kbv; kb_code = kbc;
      #1;
      if (sel && !wr) check8({tag, " read"}, bus_rdata, exp_rdata(sel, wr, addr));
      check8({tag, " led"}, {5'b0, led}, {5'b0, m_led});
      pre_obf = m_obf;
      @(posedge clk);
      model_step(sel, wr, addr, wd, kbv, kbc);
      @(negedge clk);
   endtask

   task automatic rd(bit [7:0] a, string tag);
      cyc(1, 0, a, 8'h00, 0, 8'h00, tag);
   endtask
   task automatic wr(bit [7:0] a, bit [7:0] d, string tag);
      cyc(1, 1, a, d, 0, 8'h00, tag);
   endtask
   task automatic key(bit [7:0] c, string tag);
      cyc(0, 0, 8'h00, 8'h00, 1, c, tag);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CTRL, "R1 status");
      rd(A_DATA, "R1 data");
      // R3 scancode before enable
      key(8'h1C, "R3");
      rd(A_CTRL, "R3 status");
      // R10 unknown command
      wr(A_CTRL, 8'h12, "R10");
      rd(A_CTRL, "R10 status");
      // R2 enable shows bit 3
      wr(A_CTRL, 8'hAE, "R2");
      rd(A_CTRL, "R2 status");
      // R4 capture, R5 overrun
      key(8'h1C, "R4");
      rd(A_CTRL, "R4 status");
      key(8'h32, "R5");
      rd(A_CTRL, "R5 ovr set");
      rd(A_CTRL, "R5 ovr clear");
      rd(A_DATA, "R4 data");
      rd(A_CTRL, "R4 obf clear");
      // R7 lamps
      wr(A_CTRL, 8'hED, "R7");
      rd(A_CTRL, "R7 pend");
      wr(A_DATA, 8'hFD, "R7");
      rd(A_CTRL, "R7 cleared");
      // R8 stray data write
      wr(A_DATA, 8'h02, "R8");
      rd(A_CTRL, "R8 status");
      // R9 cancel
      wr(A_CTRL, 8'hED, "R9");
      wr(A_CTRL, 8'hAE, "R9");
      rd(A_CTRL, "R9 status");
      wr(A_DATA, 8'h07, "R9");
      rd(A_CTRL, "R9 after");
      // R6 self test, scancode in busy cycle is dropped
      wr(A_CTRL, 8'hED, "R6");
      wr(A_CTRL, 8'hAA, "R6");
      cyc(1, 0, A_CTRL, 8'h00, 1, 8'h44, "R6 busy");
      rd(A_CTRL, "R6 done");
      rd(A_DATA, "R6 data");
      // R11 write during busy ignored, odd offset reads zero
      wr(A_CTRL, 8'hAA, "R11");
      wr(A_CTRL, 8'hED, "R11");
      rd(A_CTRL, "R11 status");
      rd(8'h10, "R11 other");
      cyc(1, 1, A_CTRL, 8'h00, 0, 8'h00, "R11");
      rd(A_DATA, "R11 data");

      // random phase
      for (int i = 0; i < 4000; i++) begin
         bit [7:0] a, d;
         bit s, w, kv;
         int pick = $urandom_range(0, 9);
         s = ($urandom_range(0, 3) != 0);
         w = $urandom_range(0, 1);
         a = (pick < 5) ? A_CTRL : (pick < 9) ? A_DATA : 8'($urandom_range(0, 255));
         case ($urandom_range(0, 4))
            0: d = 8'hAA;
            1: d = 8'hAE;
            2: d = 8'hED;
            default: d = 8'($urandom_range(0, 255));
         endcase
         kv = ($urandom_range(0, 2) == 0);
         cyc(s, w, a, d, kv, 8'($urandom_range(0, 255)),
             (a == A_CTRL) ? "R2 rnd" : (a == A_DATA) ? "R4 rnd" : "R11 rnd");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule